// File: doc/BRIEF.md
# USB Endpoint Transfer Completion Tracker

This block follows a single transfer on one endpoint and decides when it has ended. A transfer starts with a one-cycle `start` strobe. On that cycle the block captures the endpoint kind, the direction, the maximum packet size, the expected byte total and the terminator option. After that, a `pkt_valid` strobe reports each finished transaction.

- **Transmit direction:** the block offers the next payload size on `next_len`. A `pkt_valid` strobe means that many bytes went out.
- **Receive direction:** `pkt_len` gives the size of the packet that just arrived.

A running total is kept on `byte_cnt`.

For control, bulk and interrupt endpoints the transfer ends in any of these cases:

- the total reaches the expected length;
- a packet shorter than the maximum size arrives (this includes an empty packet);
- a received packet breaks the limits, which also raises a sticky error flag.

The end is announced by a one-cycle `done` pulse. `short_pkt` is raised alongside it when the final packet was below the maximum size. On transmit, a length that is a non-zero multiple of the packet size can be followed by one empty terminator transaction.

Isochronous endpoints only accumulate bytes and never finish. They are left through reset.

The controller has four states:

| State | Transitions |
|-------|-------------|
| IDLE | Goes to RUN on `start`. |
| RUN | On a report, goes to DONE when the transfer has ended, or to ZLP when an empty terminator is owed. |
| ZLP | Goes to DONE on the report of the empty transaction. |
| DONE | Always goes back to IDLE on the next cycle. |

Top module: `ep_xfer_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters IDLE with `done`, `short_pkt`, `ovf_err`, `byte_cnt` and `next_len` all at zero.
- R2: In RUN, `next_len` equals the smaller of the remaining bytes (expected minus counted) and the maximum packet size, so a long transfer is offered as full-size payloads followed by the remainder. Outside RUN and ZLP it is zero. `tx_dir`=1 selects transmit and `tx_dir`=0 selects receive.
- R3: The report that brings `byte_cnt` equal to the expected length ends the transfer. `done` is high in the following cycle, and `short_pkt` is high only if that last packet was below the maximum size.
- R4: On receive, a packet shorter than the maximum size ends the transfer at once, even though fewer bytes than expected have arrived, and `short_pkt` is raised with `done`.
- R5: On receive, a zero-length packet ends the transfer with `short_pkt` high and leaves `byte_cnt` unchanged.
- R6: With `ep_kind`=1 (isochronous), `done` never rises, `ovf_err` stays low and `next_len` stays at the maximum packet size. `byte_cnt` accumulates modulo 2^16. The other kinds are 0 (control), 2 (bulk) and 3 (interrupt).
- R7: A received packet longer than the maximum size, or one that would carry the count past the expected length, is not counted. It sets `ovf_err` and ends the transfer with `short_pkt` low. `ovf_err` stays high until the next accepted `start`.
- R8: On transmit with `zlp_en` high, when the last payload was full size and the length is non-zero, one more transaction with `next_len`=0 is offered before `done`, and `short_pkt` is raised then. A zero length gives a single empty transaction and no terminator.
- R9: `done` lasts exactly one cycle. During that cycle `byte_cnt` shows the final total, and in the next cycle the block is back in IDLE with `byte_cnt` at zero.
- R10: `start` is ignored in RUN, ZLP and DONE. The captured parameters and the count are unaffected.
- R11: A requested length below the maximum packet size is served by one transaction of that length, which ends the transfer with `short_pkt` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ep_kind | input | 2 | Endpoint kind: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| tx_dir | input | 1 | 1 = transmit, 0 = receive |
| max_pkt | input | MPS_W (11) | Maximum packet size, 1 to 1024 |
| xfer_len | input | LEN_W (16) | Expected transfer length, 0 to 65535 |
| zlp_en | input | 1 | Allow the empty terminator on transmit |
| start | input | 1 | Begin a transfer (taken only in IDLE) |
| pkt_valid | input | 1 | One transaction finished this cycle |
| pkt_len | input | MPS_W (11) | Received packet size (used in receive only) |
| next_len | output | MPS_W (11) | Payload size of the next transaction |
| byte_cnt | output | LEN_W (16) | Bytes counted so far in this transfer |
| done | output | 1 | One-cycle end-of-transfer pulse |
| short_pkt | output | 1 | With `done`: the last packet was below the maximum size |
| ovf_err | output | 1 | Sticky length-violation flag |

## Verification
A corrupted count or remaining length shows up on `next_len` in the same cycle. It also moves the `done` pulse one or more reports early or late, and the per-clock comparison catches that on the cycle after the report concerned. A wrong state is visible through `done` and `byte_cnt`:

- a missed DONE exit leaves `done` high for a second cycle;
- a missed terminator removes the cycle in which `next_len` is zero before `done`;
- a stale error or short flag shows up on the next pulse, or while the block waits in IDLE.

// File: rtl/ep_xfer_pkg.sv
package ep_xfer_pkg;
    typedef enum logic [1:0] {
        EP_CTRL = 2'd0,
        EP_ISO  = 2'd1,
        EP_BULK = 2'd2,
        EP_INTR = 2'd3
    } ep_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_ZLP,
        ST_DONE
    } xfer_state_e;
endpackage

// File: rtl/ep_payload_split.sv
module ep_payload_split #(
    parameter int MPS_W = 11,
    parameter int LEN_W = 16
) (
    input  logic             active,
    input  logic             iso,
    input  logic [MPS_W-1:0] mps,
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] cnt,
    output logic [MPS_W-1:0] next_len
);
    localparam int PAD_W = LEN_W - MPS_W;

    logic [LEN_W-1:0] remain;
    logic [LEN_W-1:0] mps_ext;

    always_comb begin
        remain  = len - cnt;
        mps_ext = {{PAD_W{1'b0}}, mps};
        if (!active) begin
            next_len = '0;
        end else if (iso || (remain >= mps_ext)) begin
            next_len = mps;
        end else begin
            next_len = remain[MPS_W-1:0];
        end
    end
endmodule

// File: rtl/ep_end_judge.sv
module ep_end_judge #(
    parameter int MPS_W = 11,
    parameter int LEN_W = 16
) (
    input  logic             tx,
    input  logic             iso,
    input  logic             zlp_en,
    input  logic [MPS_W-1:0] mps,
    input  logic [MPS_W-1:0] pkt,
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] cnt,
    output logic [LEN_W-1:0] sum,
    output logic             ovf,
    output logic             fin,
    output logic             short_end,
    output logic             want_zlp
);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] wide;

    always_comb begin
        wide      = {1'b0, cnt} + SUM_W'(pkt);
        sum       = wide[LEN_W-1:0];
        short_end = (pkt < mps);
        ovf       = !tx && !iso && ((pkt > mps) || (wide > {1'b0, len}));
        fin       = !iso && ((wide == {1'b0, len}) || short_end);
        want_zlp  = tx && zlp_en && (pkt == mps) && (len != '0);
    end
endmodule

// File: rtl/ep_xfer_tracker.sv
module ep_xfer_tracker
    import ep_xfer_pkg::*;
#(
    parameter int MPS_W = 11,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       ep_kind,
    input  logic             tx_dir,
    input  logic [MPS_W-1:0] max_pkt,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic             zlp_en,
    input  logic             start,
    input  logic             pkt_valid,
    input  logic [MPS_W-1:0] pkt_len,
    output logic [MPS_W-1:0] next_len,
    output logic [LEN_W-1:0] byte_cnt,
    output logic             done,
    output logic             short_pkt,
    output logic             ovf_err
);
    xfer_state_e      state_q, state_d;
    logic             iso_q, tx_q, zlp_q, err_q, short_q;
    logic [MPS_W-1:0] mps_q;
    logic [LEN_W-1:0] len_q, cnt_q;

    logic [MPS_W-1:0] offer_len, sel_len;
    logic [LEN_W-1:0] sum_w;
    logic             ovf_w, fin_w, short_w, zlp_w;

    ep_payload_split #(.MPS_W(MPS_W), .LEN_W(LEN_W)) u_split (
        .active   (state_q == ST_RUN),
        .iso      (iso_q),
        .mps      (mps_q),
        .len      (len_q),
        .cnt      (cnt_q),
        .next_len (offer_len)
    );

    assign sel_len = tx_q ? offer_len : pkt_len;

    ep_end_judge #(.MPS_W(MPS_W), .LEN_W(LEN_W)) u_judge (
        .tx        (tx_q),
        .iso       (iso_q),
        .zlp_en    (zlp_q),
        .mps       (mps_q),
        .pkt       (sel_len),
        .len       (len_q),
        .cnt       (cnt_q),
        .sum       (sum_w),
        .ovf       (ovf_w),
        .fin       (fin_w),
        .short_end (short_w),
        .want_zlp  (zlp_w)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN: begin
                if (pkt_valid) begin
                    if (ovf_w)      state_d = ST_DONE;
                    else if (fin_w) state_d = zlp_w ? ST_ZLP : ST_DONE;
                end
            end
            ST_ZLP:  if (pkt_valid) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured parameters, count and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iso_q   <= 1'b0;
            tx_q    <= 1'b0;
            zlp_q   <= 1'b0;
            mps_q   <= '0;
            len_q   <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
            short_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        iso_q   <= (ep_kind == EP_ISO);
                        tx_q    <= tx_dir;
                        zlp_q   <= zlp_en;
                        mps_q   <= max_pkt;
                        len_q   <= xfer_len;
                        cnt_q   <= '0;
                        err_q   <= 1'b0;
                        short_q <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (pkt_valid) begin
                        if (ovf_w) begin
                            err_q   <= 1'b1;
                            short_q <= 1'b0;
                        end else begin
                            cnt_q <= sum_w;
                            if (fin_w && !zlp_w) short_q <= short_w;
                        end
                    end
                end
                ST_ZLP: begin
                    if (pkt_valid) short_q <= 1'b1;
                end
                ST_DONE: begin
                    cnt_q   <= '0;
                    short_q <= 1'b0;
                end
            endcase
        end
    end

    assign next_len  = offer_len;
    assign byte_cnt  = cnt_q;
    assign done      = (state_q == ST_DONE);
    assign short_pkt = short_q;
    assign ovf_err   = err_q;

    p_payload_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (next_len <= mps_q));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !iso_q) |-> (byte_cnt <= len_q));

    p_iso_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && iso_q && pkt_valid) |=> (!done && !ovf_err));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_err && !(state_q == ST_IDLE && start)) |=> ovf_err);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && byte_cnt == '0));

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && start && !pkt_valid) |=>
            (state_q == ST_RUN && $stable(len_q) && $stable(mps_q) && $stable(byte_cnt)));
endmodule

// File: tb/tb_ep_xfer_tracker.sv
`timescale 1ns/1ps
module tb_ep_xfer_tracker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  ep_kind;
    logic        tx_dir;
    logic [10:0] max_pkt;
    logic [15:0] xfer_len;
    logic        zlp_en;
    logic        start;
    logic        pkt_valid;
    logic [10:0] pkt_len;
    logic [10:0] next_len;
    logic [15:0] byte_cnt;
    logic        done;
    logic        short_pkt;
    logic        ovf_err;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    ep_xfer_tracker dut (
        .clk(clk), .rst_n(rst_n), .ep_kind(ep_kind), .tx_dir(tx_dir),
        .max_pkt(max_pkt), .xfer_len(xfer_len), .zlp_en(zlp_en),
        .start(start), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
        .next_len(next_len), .byte_cnt(byte_cnt), .done(done),
        .short_pkt(short_pkt), .ovf_err(ovf_err)
    );

    // behavioural reference: 0 idle, 1 running, 2 terminator owed, 3 finished
    int m_st = 0, m_cnt = 0, m_len = 0, m_mps = 0;
    bit m_iso = 0, m_tx = 0, m_zlp = 0, m_err = 0, m_short = 0;

    function automatic int m_next();
        if (m_st != 1) return 0;
        if (m_iso) return m_mps;
        return ((m_len - m_cnt) < m_mps) ? (m_len - m_cnt) : m_mps;
    endfunction

    always @(posedge clk) begin
        int l;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_err = 0; m_short = 0;
        end else begin
            case (m_st)
                0: if (start) begin
                    m_iso = (ep_kind == 2'd1); m_tx = tx_dir; m_zlp = zlp_en;
                    m_mps = max_pkt; m_len = xfer_len;
                    m_cnt = 0; m_err = 0; m_short = 0; m_st = 1;
                end
                1: if (pkt_valid) begin
                    l = m_tx ? m_next() : int'(pkt_len);
                    if (m_iso) begin
                        m_cnt = (m_cnt + l) % 65536;
                    end else if (!m_tx && (l > m_mps || m_cnt + l > m_len)) begin
                        m_err = 1; m_short = 0; m_st = 3;
                    end else begin
                        m_cnt = m_cnt + l;
                        if (m_cnt == m_len || l < m_mps) begin
                            if (m_tx && m_zlp && l == m_mps && m_len > 0) m_st = 2;
                            else begin m_st = 3; m_short = (l < m_mps); end
                        end
                    end
                end
                2: if (pkt_valid) begin m_st = 3; m_short = 1; end
                default: begin m_st = 0; m_cnt = 0; m_short = 0; end
            endcase
        end
    end

    // per-clock comparison against the reference
    always @(posedge clk) begin
        #1;
        checks++;
        if (done !== (m_st == 3) || short_pkt !== m_short || ovf_err !== m_err ||
            int'(byte_cnt) != m_cnt || int'(next_len) != m_next() ||
            $isunknown({done, short_pkt, ovf_err, byte_cnt, next_len})) begin
            fails++;
            $display("FAIL %s model: actual done=%0b short=%0b err=%0b cnt=%0d next=%0d expected done=%0b short=%0b err=%0b cnt=%0d next=%0d",
                     cur_req, done, short_pkt, ovf_err, byte_cnt, next_len,
                     (m_st == 3), m_short, m_err, m_cnt, m_next());
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic begin_xfer(input int kind, input bit tx, input int mps, input int len, input bit zlp);
        ep_kind = kind[1:0]; tx_dir = tx; max_pkt = mps[10:0];
        xfer_len = len[15:0]; zlp_en = zlp; start = 1'b1;
        cyc();
        start = 1'b0;
    endtask

    task automatic rx(input int l);
        pkt_valid = 1'b1; pkt_len = l[10:0];
        cyc();
        pkt_valid = 1'b0;
    endtask

    task automatic ack();
        pkt_valid = 1'b1;
        cyc();
        pkt_valid = 1'b0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; ep_kind = '0; tx_dir = 1'b0; max_pkt = '0; xfer_len = '0;
        zlp_en = 1'b0; start = 1'b0; pkt_valid = 1'b0; pkt_len = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        chk("R1", "done", done, 0);
        chk("R1", "short", short_pkt, 0);
        chk("R1", "err", ovf_err, 0);
        chk("R1", "cnt", byte_cnt, 0);
        chk("R1", "next", next_len, 0);

        cur_req = "R2";
        begin_xfer(2, 1, 8, 20, 0);
        chk("R2", "next first", next_len, 8);
        ack(); chk("R2", "next second", next_len, 8); chk("R2", "cnt", byte_cnt, 8);
        ack(); chk("R2", "next remainder", next_len, 4);
        ack(); chk("R3", "done", done, 1); chk("R3", "cnt", byte_cnt, 20);
        chk("R3", "short", short_pkt, 1);
        cyc(); chk("R9", "done after", done, 0); chk("R9", "cnt after", byte_cnt, 0);

        cur_req = "R11";
        begin_xfer(3, 1, 64, 5, 0);
        chk("R11", "next", next_len, 5);
        ack(); chk("R11", "done", done, 1); chk("R11", "short", short_pkt, 1);
        chk("R11", "cnt", byte_cnt, 5);
        cyc();

        cur_req = "R8";
        begin_xfer(2, 1, 8, 16, 1);
        ack(); ack();
        chk("R8", "done before zlp", done, 0); chk("R8", "zlp next", next_len, 0);
        chk("R8", "cnt", byte_cnt, 16);
        ack(); chk("R8", "done", done, 1); chk("R8", "short", short_pkt, 1);
        cyc();
        cur_req = "R3";
        begin_xfer(2, 1, 8, 16, 0);
        ack(); ack();
        chk("R3", "done no zlp", done, 1); chk("R3", "short full", short_pkt, 0);
        cyc();

        cur_req = "R4";
        begin_xfer(2, 0, 8, 30, 0);
        rx(8); chk("R4", "done early", done, 0);
        rx(3); chk("R4", "done", done, 1); chk("R4", "short", short_pkt, 1);
        chk("R4", "cnt", byte_cnt, 11);
        cyc();

        cur_req = "R5";
        begin_xfer(0, 0, 8, 30, 0);
        rx(8); rx(0);
        chk("R5", "done", done, 1); chk("R5", "short", short_pkt, 1); chk("R5", "cnt", byte_cnt, 8);
        cyc();

        cur_req = "R3";
        begin_xfer(3, 0, 8, 16, 0);
        rx(8); rx(8);
        chk("R3", "rx done", done, 1); chk("R3", "rx short", short_pkt, 0);
        chk("R3", "rx cnt", byte_cnt, 16);
        cyc();

        cur_req = "R7";
        begin_xfer(2, 0, 8, 30, 0);
        rx(9);
        chk("R7", "done", done, 1); chk("R7", "err", ovf_err, 1);
        chk("R7", "short", short_pkt, 0); chk("R7", "cnt", byte_cnt, 0);
        cyc(); cyc();
        chk("R7", "sticky", ovf_err, 1);
        begin_xfer(2, 0, 8, 10, 0);
        chk("R7", "cleared", ovf_err, 0);
        rx(8); rx(8);
        chk("R7", "overshoot err", ovf_err, 1); chk("R7", "overshoot done", done, 1);
        chk("R7", "overshoot cnt", byte_cnt, 8);
        cyc();

        cur_req = "R10";
        begin_xfer(2, 0, 8, 24, 0);
        rx(8);
        max_pkt = 11'd2; xfer_len = 16'd4; start = 1'b1;
        cyc();
        start = 1'b0;
        chk("R10", "cnt", byte_cnt, 8); chk("R10", "next", next_len, 8);
        chk("R10", "done", done, 0);
        rx(8); rx(8);
        chk("R10", "done", done, 1); chk("R10", "cnt", byte_cnt, 24); chk("R10", "short", short_pkt, 0);
        cyc();

        cur_req = "R6";
        begin_xfer(1, 0, 8, 10, 0);
        rx(8); rx(8); rx(8); rx(3); rx(0);
        chk("R6", "done", done, 0); chk("R6", "cnt", byte_cnt, 27);
        chk("R6", "next", next_len, 8); chk("R6", "err", ovf_err, 0);
        cur_req = "R1";
        rst_n = 1'b0; cyc(); rst_n = 1'b1;
        chk("R1", "cnt after reset", byte_cnt, 0); chk("R1", "next after reset", next_len, 0);

        cur_req = "R2";
        begin_xfer(2, 1, 1024, 65535, 1);
        chk("R2", "big next", next_len, 1024);
        repeat (63) ack();
        chk("R2", "big remainder", next_len, 1023); chk("R2", "big cnt", byte_cnt, 64512);
        ack(); chk("R3", "big done", done, 1); chk("R3", "big cnt", byte_cnt, 65535);
        chk("R8", "no zlp for remainder", short_pkt, 1);
        cyc();

        cur_req = "R8";
        begin_xfer(2, 1, 8, 0, 1);
        chk("R8", "empty next", next_len, 0);
        ack(); chk("R8", "empty done", done, 1); chk("R8", "empty short", short_pkt, 1);
        cyc(); cyc();

        summary();
        $finish;
    end
endmodule